// File: doc/BRIEF.md
# Multiclass Interrupt Request Controller

This block gathers interrupt requests from seven classes (machine check, program exception, supervisor call, program analysis, external, timer and the I/O channels) and offers a single winner to the processor at a time. Each request is a one-cycle pulse. The block records it in a pending register, and the request waits there until the processor services it. Every class except machine check has a mask bit. A masked request is kept, not lost. The one exception is a program exception that arrives while that class is masked: it is turned into a machine check request.

The winner is held on a registered output as a class number plus an 8-bit sub-code. It stays on the output until the processor pulses an acknowledge. The acknowledge clears only the sub-source that was presented. The timer class is fed by an internal interval counter that software loads. The processor side uses the class and sub-code to pick its service routine; saving program state and fetching vectors happen elsewhere.

The block has a two-flop reset synchroniser. Every internal register sees reset asserted at once and released two clock edges after `rst_n` rises.

Top module: `intr_class_ctrl`

## Requirements
- R1: After reset `irq_valid_o` is 0, `irq_class_o` and `irq_code_o` are 0, nothing is pending and the timer is idle.
- R2: A request pulse at a clock edge sets its pending bit at that edge. The bit holds until it is acknowledged. Repeated pulses on a source that is already pending merge into one service.
- R3: `class_mask_i` bit assignment, where 1 means masked: bit 0 program exception, bit 1 supervisor call, bit 2 program analysis, bit 3 external, bit 4 timer, bit 5 I/O. A masked class is never presented, and its pending requests are presented once the bit is cleared. Machine check cannot be masked.
- R4: A program exception pulse while mask bit 0 is set raises a machine check with code 1 and leaves no program exception pending.
- R5: Class numbers, which also give fixed priority from highest to lowest: 0 machine check, 1 program exception, 2 supervisor call, 3 program analysis, 4 external, 5 timer, 6 I/O.
- R6: When one class has several pending sub-sources, the lowest-numbered one is presented first.
- R7: Sub-codes are defined per class:
  - Machine check: 0 for a hardware fault, 1 for an escalated program exception.
  - Program exception: the index of the exception line.
  - Supervisor call: the 8-bit code captured when the call is accepted. A call that arrives while another call is pending is ignored.
  - External: line index, where 0 is maintenance trace, 1 is interrupt key and 2 to 7 are external signal lines 2 to 7.
  - I/O: channel index, where 0 to 2 are selector channels and 3 to 4 are multiplexer channels.
  - Program analysis and timer: 0.
- R8: Loading the timer with N > 0 at edge k makes the timer request pending at edge k+N. Loading 0 stops a running count without a request.
- R9: While `irq_valid_o` is 1 and no acknowledge is given, class and code stay stable, even if a higher-priority request arrives.
- R10: An acknowledge while `irq_valid_o` is 1 drops valid at that edge and clears only the presented sub-source. The next winner appears one edge later. An acknowledge while valid is 0 has no effect.
- R11: An unmasked request pulsed at edge k, with nothing presented, appears on the outputs at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mchk_hw_i | input | 1 | Hardware fault pulse |
| pgm_exc_i | input | N_PGM | Program exception pulses, one per exception type |
| svc_i | input | 1 | Supervisor call pulse |
| svc_code_i | input | 8 | Supervisor call code |
| prog_anl_i | input | 1 | Program analysis pulse |
| ext_evt_i | input | N_EXT | External event pulses |
| tmr_load_i | input | 1 | Load strobe for the interval timer |
| tmr_value_i | input | TMR_W | Interval in clock cycles |
| io_chan_i | input | N_IO | Per-channel I/O request pulses |
| class_mask_i | input | 6 | Per-class mask, 1 = masked |
| irq_valid_o | output | 1 | A request is presented |
| irq_class_o | output | 3 | Class number of the presented request |
| irq_code_o | output | 8 | Sub-code of the presented request |
| irq_ack_i | input | 1 | Service acknowledge pulse |

## Verification
The assertions check the following on every cycle:
- The presented class and code hold steady until an acknowledge.
- An acknowledge always drops valid.
- A newly presented class is never one that was masked.
- A masked program exception always turns into a machine check and never leaves a program exception pending.
- Pending analysis requests and captured supervisor codes survive until cleared.
- The timer stops after it fires or after a zero load.

Only the bench scenarios can show the rest, because each needs a planned sequence of events and the expected service order:
- The full priority order across all classes.
- Lowest-index ordering within a class.
- Merging of repeated pulses.
- That an acknowledge clears only the presented sub-source.
- Exact timer and presentation latencies.
- That an acknowledge while idle does nothing.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int CLS_W  = 3;
  localparam int CODE_W = 8;
  localparam int MASK_W = 6;

  localparam int MB_PGM = 0;
  localparam int MB_SVC = 1;
  localparam int MB_PAN = 2;
  localparam int MB_EXT = 3;
  localparam int MB_TMR = 4;
  localparam int MB_IO  = 5;

  typedef enum logic [CLS_W-1:0] {
    CLS_MCHK = 3'd0,
    CLS_PGM  = 3'd1,
    CLS_SVC  = 3'd2,
    CLS_PAN  = 3'd3,
    CLS_EXT  = 3'd4,
    CLS_TMR  = 3'd5,
    CLS_IO   = 3'd6
  } intr_cls_e;

  // index of the lowest set bit, zero when none is set
  function automatic logic [CODE_W-1:0] lowest_set(input logic [31:0] v);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = CODE_W'(i);
    end
    return r;
  endfunction

  function automatic logic cls_masked(input logic [MASK_W-1:0] m, input intr_cls_e c);
    logic r;
    case (c)
      CLS_MCHK: r = 1'b0;
      CLS_PGM:  r = m[MB_PGM];
      CLS_SVC:  r = m[MB_SVC];
      CLS_PAN:  r = m[MB_PAN];
      CLS_EXT:  r = m[MB_EXT];
      CLS_TMR:  r = m[MB_TMR];
      CLS_IO:   r = m[MB_IO];
      default:  r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/intc_timer.sv
module intc_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] value_i,
  output logic             expire_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  assign expire_o = run_q && (cnt_q == TMR_W'(1)) && !load_i;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_i) begin
      cnt_d = value_i;
      run_d = (value_i != '0);
    end else if (run_q) begin
      cnt_d = cnt_q - TMR_W'(1);
      if (cnt_q == TMR_W'(1)) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R8: a zero load leaves the counter stopped
  a_r8_zero_load_stops: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_i && value_i == '0) |=> !run_q);
  // R8: expiry is a single event, the count is spent afterwards
  a_r8_expire_once: assert property (@(posedge clk) disable iff (!rst_ni)
    expire_o |=> (!run_q && cnt_q == '0));
endmodule

// File: rtl/intc_pending.sv
module intc_pending
  import intc_pkg::*;
#(
  parameter int N_PGM = 16,
  parameter int N_EXT = 8,
  parameter int N_IO  = 5
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              mchk_hw_i,
  input  logic [N_PGM-1:0]  pgm_exc_i,
  input  logic              svc_i,
  input  logic [CODE_W-1:0] svc_code_i,
  input  logic              prog_anl_i,
  input  logic [N_EXT-1:0]  ext_evt_i,
  input  logic              tmr_exp_i,
  input  logic [N_IO-1:0]   io_chan_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              clr_i,
  input  intr_cls_e         clr_cls_i,
  input  logic [CODE_W-1:0] clr_code_i,
  output logic [1:0]        mchk_o,
  output logic [N_PGM-1:0]  pgm_o,
  output logic              svc_o,
  output logic [CODE_W-1:0] svc_code_o,
  output logic              anl_o,
  output logic [N_EXT-1:0]  ext_o,
  output logic              tmr_o,
  output logic [N_IO-1:0]   io_o
);
  logic [1:0]        mchk_q, mchk_d, mchk_clr;
  logic [N_PGM-1:0]  pgm_q, pgm_d, pgm_clr;
  logic [N_EXT-1:0]  ext_q, ext_d, ext_clr;
  logic [N_IO-1:0]   io_q, io_d, io_clr;
  logic              svc_q, svc_d, anl_q, anl_d, tmr_q, tmr_d;
  logic [CODE_W-1:0] svcc_q, svcc_d;
  logic              esc, svc_clr, svc_open;

  function automatic logic hit(input logic c, input intr_cls_e cc, input intr_cls_e want,
                               input logic [CODE_W-1:0] code, input int idx);
    return c && (cc == want) && (code == CODE_W'(idx));
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_mclr
    assign mchk_clr[g] = hit(clr_i, clr_cls_i, CLS_MCHK, clr_code_i, g);
  end
  for (genvar g = 0; g < N_PGM; g++) begin : g_pclr
    assign pgm_clr[g] = hit(clr_i, clr_cls_i, CLS_PGM, clr_code_i, g);
  end
  for (genvar g = 0; g < N_EXT; g++) begin : g_eclr
    assign ext_clr[g] = hit(clr_i, clr_cls_i, CLS_EXT, clr_code_i, g);
  end
  for (genvar g = 0; g < N_IO; g++) begin : g_iclr
    assign io_clr[g] = hit(clr_i, clr_cls_i, CLS_IO, clr_code_i, g);
  end

  assign esc      = (|pgm_exc_i) && mask_i[MB_PGM];
  assign svc_clr  = clr_i && (clr_cls_i == CLS_SVC);
  assign svc_open = !svc_q || svc_clr;

  always_comb begin
    mchk_d = (mchk_q & ~mchk_clr) | {esc, mchk_hw_i};
    pgm_d  = (pgm_q & ~pgm_clr) | (pgm_exc_i & {N_PGM{~mask_i[MB_PGM]}});
    ext_d  = (ext_q & ~ext_clr) | ext_evt_i;
    io_d   = (io_q & ~io_clr) | io_chan_i;
    anl_d  = (anl_q && !(clr_i && clr_cls_i == CLS_PAN)) || prog_anl_i;
    tmr_d  = (tmr_q && !(clr_i && clr_cls_i == CLS_TMR)) || tmr_exp_i;
    svc_d  = svc_q;
    svcc_d = svcc_q;
    if (svc_i && svc_open) begin
      svc_d  = 1'b1;
      svcc_d = svc_code_i;
    end else if (svc_clr) begin
      svc_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mchk_q <= '0;
      pgm_q  <= '0;
      ext_q  <= '0;
      io_q   <= '0;
      anl_q  <= 1'b0;
      tmr_q  <= 1'b0;
      svc_q  <= 1'b0;
      svcc_q <= '0;
    end else begin
      mchk_q <= mchk_d;
      pgm_q  <= pgm_d;
      ext_q  <= ext_d;
      io_q   <= io_d;
      anl_q  <= anl_d;
      tmr_q  <= tmr_d;
      svc_q  <= svc_d;
      svcc_q <= svcc_d;
    end
  end

  assign mchk_o     = mchk_q;
  assign pgm_o      = pgm_q;
  assign ext_o      = ext_q;
  assign io_o       = io_q;
  assign anl_o      = anl_q;
  assign tmr_o      = tmr_q;
  assign svc_o      = svc_q;
  assign svc_code_o = svcc_q;

  // R4: masked program exception escalates to machine check
  a_r4_escalate: assert property (@(posedge clk) disable iff (!rst_ni)
    ((|pgm_exc_i) && mask_i[MB_PGM]) |=> mchk_q[1]);
  // R4: a masked program exception never shows up as pending
  a_r4_masked_pgm_out: assert property (@(posedge clk) disable iff (!rst_ni)
    (pgm_q == '0 && (mask_i[MB_PGM] || pgm_exc_i == '0)) |=> pgm_q == '0);
  // R2: a pending request survives until its clear
  a_r2_anl_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (anl_q && !(clr_i && clr_cls_i == CLS_PAN)) |=> anl_q);
  // R7: a captured supervisor code is not overwritten while pending
  a_r7_svc_code_held: assert property (@(posedge clk) disable iff (!rst_ni)
    (svc_q && !svc_clr) |=> (svc_q && $stable(svcc_q)));
endmodule

// File: rtl/intc_select.sv
module intc_select
  import intc_pkg::*;
#(
  parameter int N_PGM = 16,
  parameter int N_EXT = 8,
  parameter int N_IO  = 5
) (
  input  logic [1:0]        mchk_i,
  input  logic [N_PGM-1:0]  pgm_i,
  input  logic              svc_i,
  input  logic [CODE_W-1:0] svc_code_i,
  input  logic              anl_i,
  input  logic [N_EXT-1:0]  ext_i,
  input  logic              tmr_i,
  input  logic [N_IO-1:0]   io_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              any_o,
  output intr_cls_e         cls_o,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    any_o  = 1'b1;
    cls_o  = CLS_MCHK;
    code_o = '0;
    if (|mchk_i) begin
      code_o = lowest_set(32'(mchk_i));
    end else if ((|pgm_i) && !mask_i[MB_PGM]) begin
      cls_o  = CLS_PGM;
      code_o = lowest_set(32'(pgm_i));
    end else if (svc_i && !mask_i[MB_SVC]) begin
      cls_o  = CLS_SVC;
      code_o = svc_code_i;
    end else if (anl_i && !mask_i[MB_PAN]) begin
      cls_o  = CLS_PAN;
    end else if ((|ext_i) && !mask_i[MB_EXT]) begin
      cls_o  = CLS_EXT;
      code_o = lowest_set(32'(ext_i));
    end else if (tmr_i && !mask_i[MB_TMR]) begin
      cls_o  = CLS_TMR;
    end else if ((|io_i) && !mask_i[MB_IO]) begin
      cls_o  = CLS_IO;
      code_o = lowest_set(32'(io_i));
    end else begin
      any_o  = 1'b0;
    end
  end
endmodule

// File: rtl/intr_class_ctrl.sv
module intr_class_ctrl
  import intc_pkg::*;
#(
  parameter int N_PGM = 16,
  parameter int N_EXT = 8,
  parameter int N_IO  = 5,
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mchk_hw_i,
  input  logic [N_PGM-1:0]  pgm_exc_i,
  input  logic              svc_i,
  input  logic [CODE_W-1:0] svc_code_i,
  input  logic              prog_anl_i,
  input  logic [N_EXT-1:0]  ext_evt_i,
  input  logic              tmr_load_i,
  input  logic [TMR_W-1:0]  tmr_value_i,
  input  logic [N_IO-1:0]   io_chan_i,
  input  logic [MASK_W-1:0] class_mask_i,
  output logic              irq_valid_o,
  output logic [CLS_W-1:0]  irq_class_o,
  output logic [CODE_W-1:0] irq_code_o,
  input  logic              irq_ack_i
);
  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic              tmr_exp;
  logic [1:0]        p_mchk;
  logic [N_PGM-1:0]  p_pgm;
  logic              p_svc, p_anl, p_tmr;
  logic [CODE_W-1:0] p_svcc;
  logic [N_EXT-1:0]  p_ext;
  logic [N_IO-1:0]   p_io;
  logic              sel_any;
  intr_cls_e         sel_cls;
  logic [CODE_W-1:0] sel_code;

  logic              valid_q, valid_d, clr;
  intr_cls_e         cls_q, cls_d;
  logic [CODE_W-1:0] code_q, code_d;

  assign clr = valid_q && irq_ack_i;

  intc_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_ni(rst_s_n), .load_i(tmr_load_i), .value_i(tmr_value_i),
    .expire_o(tmr_exp)
  );

  intc_pending #(.N_PGM(N_PGM), .N_EXT(N_EXT), .N_IO(N_IO)) u_pend (
    .clk(clk), .rst_ni(rst_s_n),
    .mchk_hw_i(mchk_hw_i), .pgm_exc_i(pgm_exc_i), .svc_i(svc_i),
    .svc_code_i(svc_code_i), .prog_anl_i(prog_anl_i), .ext_evt_i(ext_evt_i),
    .tmr_exp_i(tmr_exp), .io_chan_i(io_chan_i), .mask_i(class_mask_i),
    .clr_i(clr), .clr_cls_i(cls_q), .clr_code_i(code_q),
    .mchk_o(p_mchk), .pgm_o(p_pgm), .svc_o(p_svc), .svc_code_o(p_svcc),
    .anl_o(p_anl), .ext_o(p_ext), .tmr_o(p_tmr), .io_o(p_io)
  );

  intc_select #(.N_PGM(N_PGM), .N_EXT(N_EXT), .N_IO(N_IO)) u_sel (
    .mchk_i(p_mchk), .pgm_i(p_pgm), .svc_i(p_svc), .svc_code_i(p_svcc),
    .anl_i(p_anl), .ext_i(p_ext), .tmr_i(p_tmr), .io_i(p_io),
    .mask_i(class_mask_i), .any_o(sel_any), .cls_o(sel_cls), .code_o(sel_code)
  );

  always_comb begin
    valid_d = valid_q;
    cls_d   = cls_q;
    code_d  = code_q;
    if (clr) begin
      valid_d = 1'b0;
    end else if (!valid_q && sel_any) begin
      valid_d = 1'b1;
      cls_d   = sel_cls;
      code_d  = sel_code;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      valid_q <= 1'b0;
      cls_q   <= CLS_MCHK;
      code_q  <= '0;
    end else begin
      valid_q <= valid_d;
      cls_q   <= cls_d;
      code_q  <= code_d;
    end
  end

  assign irq_valid_o = valid_q;
  assign irq_class_o = cls_q;
  assign irq_code_o  = code_q;

  // R9: presented request is frozen until acknowledged
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_valid_o && !irq_ack_i) |=> (irq_valid_o && $stable(irq_class_o) && $stable(irq_code_o)));
  // R10: acknowledge of a presented request drops valid
  a_r10_ack_drops: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_valid_o && irq_ack_i) |=> !irq_valid_o);
  // R3: a class that was masked is never newly presented
  a_r3_no_masked_win: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(irq_valid_o) |-> !cls_masked($past(class_mask_i), cls_q));
endmodule

// File: tb/sim_intr_class_ctrl.sv
`timescale 1ns/1ps
module sim_intr_class_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mchk_hw_i = 0;
  logic [15:0] pgm_exc_i = '0;
  logic        svc_i = 0;
  logic [7:0]  svc_code_i = '0;
  logic        prog_anl_i = 0;
  logic [7:0]  ext_evt_i = '0;
  logic        tmr_load_i = 0;
  logic [15:0] tmr_value_i = '0;
  logic [4:0]  io_chan_i = '0;
  logic [5:0]  class_mask_i = '0;
  logic        irq_valid_o;
  logic [2:0]  irq_class_o;
  logic [7:0]  irq_code_o;
  logic        drv_ack = 0, mon_ack = 0, irq_ack_i;
  logic        mon_en = 0;
  int          n_run = 0, n_fail = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  assign irq_ack_i = drv_ack | mon_ack;
  always #10 clk = ~clk;

  intr_class_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mchk_hw_i(mchk_hw_i), .pgm_exc_i(pgm_exc_i),
    .svc_i(svc_i), .svc_code_i(svc_code_i), .prog_anl_i(prog_anl_i),
    .ext_evt_i(ext_evt_i), .tmr_load_i(tmr_load_i), .tmr_value_i(tmr_value_i),
    .io_chan_i(io_chan_i), .class_mask_i(class_mask_i), .irq_valid_o(irq_valid_o),
    .irq_class_o(irq_class_o), .irq_code_o(irq_code_o), .irq_ack_i(irq_ack_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic [7:0] k, input string tag);
    exp_q.push_back({c, k});
    tag_q.push_back(tag);
  endtask

  task automatic drain(input string tag);
    mon_en = 1;
    for (int i = 0; i < 300 && exp_q.size() > 0; i++) @(negedge clk);
    chk({tag, " all expected served"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
    repeat (4) @(negedge clk);
    chk({tag, " nothing extra presented"}, irq_valid_o, 0);
    mon_en = 0;
  endtask

  // monitor: scoreboard compare and acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && irq_valid_o) begin
        if (exp_q.size() == 0) begin
          chk("unexpected request presented", {irq_class_o, irq_code_o}, 11'h7ff);
        end else begin
          logic [10:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {irq_class_o, irq_code_o}, e);
        end
        mon_ack = 1;
        @(negedge clk);
        mon_ack = 0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 reset valid", irq_valid_o, 0);
    chk("R1 reset class", irq_class_o, 0);
    chk("R1 reset code", irq_code_o, 0);

    // R5 R6 R7: all classes together, served in priority order
    push(0, 8'h00, "R5 mchk first");
    push(1, 8'h03, "R6 pgm lowest");
    push(1, 8'h05, "R6 pgm next");
    push(2, 8'hA5, "R7 svc code");
    push(3, 8'h00, "R5 analysis");
    push(4, 8'h01, "R7 ext key");
    push(4, 8'h06, "R6 ext signal 6");
    push(6, 8'h01, "R6 io ch1");
    push(6, 8'h04, "R7 io ch4");
    mchk_hw_i = 1; pgm_exc_i = 16'h0028; svc_i = 1; svc_code_i = 8'hA5;
    prog_anl_i = 1; ext_evt_i = 8'h42; io_chan_i = 5'b10010;
    @(negedge clk);
    mchk_hw_i = 0; pgm_exc_i = '0; svc_i = 0; prog_anl_i = 0; ext_evt_i = '0; io_chan_i = '0;
    drain("R5 mixed");

    // R4 escalation
    class_mask_i = 6'b000001;
    push(0, 8'h01, "R4 escalated mchk code");
    pgm_exc_i = 16'h0004;
    @(negedge clk);
    pgm_exc_i = '0;
    drain("R4");
    class_mask_i = '0;
    repeat (5) @(negedge clk);
    chk("R4 no pgm left pending", irq_valid_o, 0);

    // R3 mask hold and R9 stability
    class_mask_i = 6'b001000;
    ext_evt_i = 8'h10;
    @(negedge clk);
    ext_evt_i = '0;
    repeat (5) @(negedge clk);
    chk("R3 masked ext not shown", irq_valid_o, 0);
    io_chan_i = 5'b00100;
    @(negedge clk);
    io_chan_i = '0;
    @(negedge clk);
    chk("R3 io passes ext mask", {irq_valid_o, irq_class_o, irq_code_o}, {1'b1, 3'd6, 8'd2});
    mchk_hw_i = 1;
    @(negedge clk);
    mchk_hw_i = 0;
    repeat (3) @(negedge clk);
    chk("R9 held despite mchk", {irq_valid_o, irq_class_o, irq_code_o}, {1'b1, 3'd6, 8'd2});
    push(6, 8'h02, "R9 io served");
    push(0, 8'h00, "R9 mchk after");
    push(4, 8'h04, "R3 ext after unmask");
    class_mask_i = '0;
    drain("R3");

    // R7 second svc while pending ignored
    svc_i = 1; svc_code_i = 8'h11;
    @(negedge clk);
    svc_code_i = 8'h22;
    @(negedge clk);
    svc_i = 0;
    push(2, 8'h11, "R7 first svc code kept");
    drain("R7 svc");

    // R2 merge
    pgm_exc_i = 16'h0002;
    repeat (2) @(negedge clk);
    pgm_exc_i = '0;
    push(1, 8'h01, "R2 merged pgm");
    drain("R2");

    // R8 timer latency
    tmr_load_i = 1; tmr_value_i = 16'd10;
    @(negedge clk);
    tmr_load_i = 0;
    repeat (10) @(negedge clk);
    chk("R8 not yet at k+10", irq_valid_o, 0);
    @(negedge clk);
    chk("R8 timer shown at k+11", {irq_valid_o, irq_class_o, irq_code_o}, {1'b1, 3'd5, 8'd0});
    push(5, 8'h00, "R8 timer served");
    drain("R8");
    tmr_load_i = 1; tmr_value_i = 16'd20;
    @(negedge clk);
    tmr_load_i = 0;
    repeat (5) @(negedge clk);
    tmr_load_i = 1; tmr_value_i = 16'd0;
    @(negedge clk);
    tmr_load_i = 0;
    repeat (30) @(negedge clk);
    chk("R8 zero load cancels", irq_valid_o, 0);

    // R11 latency
    prog_anl_i = 1;
    @(negedge clk);
    prog_anl_i = 0;
    chk("R11 not at edge k", irq_valid_o, 0);
    @(negedge clk);
    chk("R11 shown at k+1", {irq_valid_o, irq_class_o}, {1'b1, 3'd3});
    push(3, 8'h00, "R11 served");
    drain("R11");

    // R10 ack while idle ignored
    class_mask_i = 6'b100000;
    io_chan_i = 5'b01000;
    @(negedge clk);
    io_chan_i = '0;
    repeat (2) @(negedge clk);
    drv_ack = 1;
    @(negedge clk);
    drv_ack = 0;
    class_mask_i = '0;
    push(6, 8'h03, "R10 idle ack ignored");
    drain("R10 idle");

    // R10 ack clears only presented, one-cycle gap
    io_chan_i = 5'b00011;
    @(negedge clk);
    io_chan_i = '0;
    @(negedge clk);
    chk("R10 first channel", {irq_valid_o, irq_class_o, irq_code_o}, {1'b1, 3'd6, 8'd0});
    drv_ack = 1;
    @(negedge clk);
    drv_ack = 0;
    chk("R10 valid drops", irq_valid_o, 0);
    @(negedge clk);
    chk("R10 other channel kept", {irq_valid_o, irq_class_o, irq_code_o}, {1'b1, 3'd6, 8'd1});
    push(6, 8'h01, "R10 second served");
    drain("R10 gap");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule